// File: doc/BRIEF.md
# Time-Multiplexed Six-Channel Servo Pulse Generator

This block drives six servo lines from one shared pulse-width counter and comparator. Real frames carry one channel's pulse, and each real frame is routed to exactly one servo through a per-channel select. Between two real frames the block runs a short zero-duty filler frame. In that window it clears every select, loads the next channel's programmed width into a staging register, raises the select of that channel, and then ends the filler frame early. To end it, the rollover compare is pointed at the counter's present value, so the counter wraps and latches the staged width in a single step.

Software programs one 10-bit width per channel over a small write port. It sets the real-frame period and gates the whole sequence with an enable. A width write is picked up the next time that channel is staged, so a pulse that is already in progress is never altered. The channel index output shows which servo owns the current frame pair.

Top module: `servo_mux_pwm`

## Requirements
- R1: While reset is asserted, and on the first sampled cycle after it, all six servo outputs are low and the channel index is 0.
- R2: In its real frame, servo k is high for exactly width[k] consecutive clock cycles when 1 <= width[k] <= period+1. A real frame lasts period+1 cycles.
- R3: A width of 0 gives no pulse. A width greater than period+1 gives a pulse of exactly period+1 cycles, which ends when the real frame ends.
- R4: At most one servo output is high in any cycle. A high output is always the one whose index equals the channel index output.
- R5: The channel index advances by one at the end of each real frame and wraps from 5 to 0. Successive changes of the index are period+4 cycles apart.
- R6: A write to width[k] (wr_en high with wr_addr = k, where k < 6) does not change a pulse of channel k that is already in progress. It takes effect from the next real frame of channel k.
- R7: Every real frame is preceded by a filler frame of 3 cycles. During the filler frame the duty is zero and all selects are cleared. The pulse of the newly selected channel starts 3 cycles after the channel index changes.
- R8: When the enable is low, all servo outputs go low on the next cycle and the channel index holds. When the enable returns high, the sequence resumes with a filler frame followed by a full pulse for the same channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Runs the frame sequence when high |
| period_i | input | 10 | Last counter value of a real frame |
| wr_en | input | 1 | Width write strobe |
| wr_addr | input | 3 | Channel to write; values 6 and 7 are ignored |
| wr_data | input | 10 | Width in clock cycles |
| servo_o | output | 6 | Gated servo pulse lines |
| ch_o | output | 3 | Channel owning the current frame pair |

## Verification
The outputs are combinational from registers, so a change is visible at the first falling edge after the clock edge that causes it. A width write is registered on the next rising edge. A change of the channel index is therefore seen one sample after the real frame's final count. The rise of the next pulse comes 3 samples later, and the next index change comes period+4 samples after the first. A monitor samples on falling edges, counts the high cycles of each channel's frame, and records each pulse's rise offset and each frame's spacing at the sample where the index changes. The directed tasks compare only those stored per-frame values. They wait on completed frames, never on fixed delays, and the disable check samples one falling edge after the enable drops.

// File: rtl/servo_mux_pkg.sv
package servo_mux_pkg;
    localparam int unsigned SERVO_COUNT = 6;
    localparam int unsigned WIDTH_BITS  = 10;

    typedef enum logic {
        FR_FILL = 1'b0,
        FR_LIVE = 1'b1
    } frame_e;
endpackage

// File: rtl/servo_width_regs.sv
module servo_width_regs #(
    parameter int unsigned N   = 6,
    parameter int unsigned W   = 10,
    localparam int unsigned CHW = (N > 1) ? $clog2(N) : 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           wr_en,
    input  logic [CHW-1:0] wr_addr,
    input  logic [W-1:0]   wr_data,
    input  logic [CHW-1:0] rd_addr,
    output logic [W-1:0]   rd_data
);
    logic [W-1:0] bank_q [N];
    logic [W-1:0] bank_d [N];

    always_comb begin
        for (int i = 0; i < N; i++) begin
            bank_d[i] = bank_q[i];
            if (wr_en && (int'(wr_addr) == i)) begin
                bank_d[i] = wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (rst) bank_q[i] <= '0;
            else     bank_q[i] <= bank_d[i];
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < N; i++) begin
            if (int'(rd_addr) == i) rd_data = bank_q[i];
        end
    end
endmodule

// File: rtl/servo_frame_seq.sv
module servo_frame_seq
    import servo_mux_pkg::*;
#(
    parameter int unsigned N   = 6,
    parameter int unsigned W   = 10,
    localparam int unsigned CHW = (N > 1) ? $clog2(N) : 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           en,
    input  logic [W-1:0]   period_i,
    input  logic [W-1:0]   width_i,
    output logic [CHW-1:0] ch_o,
    output logic [N-1:0]   sel_o,
    output logic [W-1:0]   cnt_o,
    output logic [W-1:0]   duty_o
);
    localparam logic [W-1:0]   STEP_LOAD  = W'(0);
    localparam logic [W-1:0]   STEP_SEL   = W'(1);
    localparam logic [W-1:0]   STEP_FORCE = W'(2);
    localparam logic [CHW-1:0] CH_LAST    = CHW'(N - 1);

    typedef struct packed {
        frame_e         frame;
        logic [W-1:0]   cnt;
        logic [W-1:0]   duty;
        logic [W-1:0]   pend;
        logic [N-1:0]   sel;
        logic [CHW-1:0] ch;
    } seq_t;

    seq_t s_q, s_d;
    logic [W-1:0] cmp_per;
    logic         roll;

    always_comb begin
        // A filler frame never matches the period; at its last step the
        // compare is pointed at the live count so the counter wraps at once.
        if (s_q.frame == FR_FILL) begin
            cmp_per = (s_q.cnt == STEP_FORCE) ? s_q.cnt : '1;
        end else begin
            cmp_per = period_i;
        end
        roll = (s_q.cnt >= cmp_per);

        s_d = s_q;
        if (!en) begin
            s_d.frame = FR_FILL;
            s_d.cnt   = '0;
            s_d.duty  = '0;
            s_d.pend  = '0;
            s_d.sel   = '0;
        end else if (roll) begin
            s_d.cnt  = '0;
            s_d.duty = s_q.pend;
            if (s_q.frame == FR_LIVE) begin
                s_d.frame = FR_FILL;
                s_d.sel   = '0;
                s_d.ch    = (s_q.ch == CH_LAST) ? '0 : s_q.ch + 1'b1;
            end else begin
                s_d.frame = FR_LIVE;
                s_d.pend  = '0;
            end
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
            if (s_q.frame == FR_FILL) begin
                if (s_q.cnt == STEP_LOAD) s_d.pend = width_i;
                if (s_q.cnt == STEP_SEL) begin
                    s_d.sel        = '0;
                    s_d.sel[s_q.ch] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '{frame: FR_FILL, cnt: '0, duty: '0, pend: '0, sel: '0, ch: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign ch_o   = s_q.ch;
    assign sel_o  = s_q.sel;
    assign cnt_o  = s_q.cnt;
    assign duty_o = s_q.duty;

    // R7: no duty is ever live inside a filler frame
    p_fill_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (s_q.frame == FR_FILL) |-> (s_q.duty == '0));

    // R7: selects are cleared on entry to a filler frame
    p_sel_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (en && s_q.frame == FR_LIVE && roll) |=> (s_q.sel == '0));

    // R4: the select never moves inside a live frame
    p_sel_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (en && s_q.frame == FR_LIVE && !roll) |=> $stable(s_q.sel));

    // R5: index steps by one with wrap at the end of a live frame
    p_ch_step_r5: assert property (@(posedge clk) disable iff (rst)
        (en && s_q.frame == FR_LIVE && roll) |=>
        (s_q.ch == (($past(s_q.ch) == CH_LAST) ? '0 : $past(s_q.ch) + 1'b1)));

    // R5: index stays in range
    p_ch_range_r5: assert property (@(posedge clk) disable iff (rst)
        (int'(s_q.ch) < N));

    // R8: disable clears the select and freezes the index
    p_disable_r8: assert property (@(posedge clk) disable iff (rst)
        (!en) |=> ((s_q.sel == '0) && $stable(s_q.ch)));
endmodule

// File: rtl/servo_out_gate.sv
module servo_out_gate #(
    parameter int unsigned N = 6,
    parameter int unsigned W = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] cnt_i,
    input  logic [W-1:0] duty_i,
    input  logic [N-1:0] sel_i,
    output logic [N-1:0] servo_o
);
    logic pulse;
    assign pulse = (cnt_i < duty_i);

    for (genvar k = 0; k < N; k++) begin : g_line
        assign servo_o[k] = pulse & sel_i[k];
    end

    // R4: at most one servo line is high
    p_onehot_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(servo_o));
endmodule

// File: rtl/servo_mux_pwm.sv
module servo_mux_pwm
    import servo_mux_pkg::*;
#(
    parameter int unsigned N   = SERVO_COUNT,
    parameter int unsigned W   = WIDTH_BITS,
    localparam int unsigned CHW = (N > 1) ? $clog2(N) : 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           en,
    input  logic [W-1:0]   period_i,
    input  logic           wr_en,
    input  logic [CHW-1:0] wr_addr,
    input  logic [W-1:0]   wr_data,
    output logic [N-1:0]   servo_o,
    output logic [CHW-1:0] ch_o
);
    logic [W-1:0] width_sel;
    logic [N-1:0] sel;
    logic [W-1:0] cnt;
    logic [W-1:0] duty;

    servo_width_regs #(.N(N), .W(W)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(ch_o), .rd_data(width_sel)
    );

    servo_frame_seq #(.N(N), .W(W)) u_seq (
        .clk(clk), .rst(rst), .en(en), .period_i(period_i),
        .width_i(width_sel), .ch_o(ch_o), .sel_o(sel),
        .cnt_o(cnt), .duty_o(duty)
    );

    servo_out_gate #(.N(N), .W(W)) u_gate (
        .clk(clk), .rst(rst), .cnt_i(cnt), .duty_i(duty),
        .sel_i(sel), .servo_o(servo_o)
    );
endmodule

// File: tb/tb_servo_mux_pwm.sv
module tb_servo_mux_pwm;
    localparam int N = 6;
    localparam int PER = 20;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0;
    logic [9:0] period_i = 10'(PER);
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [9:0] wr_data = '0;
    logic [5:0] servo_o;
    logic [2:0] ch_o;

    servo_mux_pwm dut (
        .clk(clk), .rst(rst), .en(en), .period_i(period_i), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .servo_o(servo_o), .ch_o(ch_o)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int hist_w [N];
    int hist_gap [N];
    int last_span = 0;
    int last_ch = 0;
    int frames_done = 0;
    int viol = 0;
    int prev_ch = 0;
    int hi = 0;
    int since = 0;
    int gap = -1;
    bit prev_hi = 0;

    always @(negedge clk) begin
        if (rst) begin
            prev_ch = 0; hi = 0; since = 0; gap = -1; prev_hi = 0;
        end else begin
            if (int'(ch_o) != prev_ch) begin
                hist_w[prev_ch] = hi;
                hist_gap[prev_ch] = gap;
                last_span = since + 1;
                last_ch = prev_ch;
                hi = 0; since = 0; gap = -1;
                prev_ch = int'(ch_o);
                frames_done++;
            end else begin
                since++;
            end
            if (!en) hi = 0;
            if (servo_o[ch_o]) begin
                hi++;
                if (!prev_hi) gap = since;
            end
            prev_hi = servo_o[ch_o];
            if (($countones(servo_o) > 1) || ((servo_o & ~(6'd1 << ch_o)) != 6'd0)) viol++;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_w(input int k, input int v);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'(k); wr_data = 10'(v);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_leave(input int k);
        bit hit = 0;
        while (!hit) begin
            @(frames_done);
            if (last_ch == k) hit = 1;
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 servo in reset", int'(servo_o), 0);
        check("R1 ch in reset", int'(ch_o), 0);
        rst = 1'b0;
        en = 1'b1;
        @(negedge clk);
        check("R1 servo after reset", int'(servo_o), 0);
        check("R1 ch after reset", int'(ch_o), 0);
    endtask

    task automatic t_sweep();
        int exp_w [N] = '{5, 9, 13, 2, 17, 7};
        for (int k = 0; k < N; k++) write_w(k, exp_w[k]);
        wait_leave(5);
        wait_leave(5);
        for (int k = 0; k < N; k++) begin
            check($sformatf("R2 width ch%0d", k), hist_w[k], exp_w[k]);
            check($sformatf("R7 rise offset ch%0d", k), hist_gap[k], 3);
        end
        check("R5 frame spacing", last_span, PER + 4);
        check("R4 cross-channel pulses", viol, 0);
    endtask

    task automatic t_order();
        int prev;
        wait_leave(0);
        prev = 0;
        for (int i = 0; i < 8; i++) begin
            @(frames_done);
            check("R5 channel order", last_ch, (prev + 1) % N);
            check("R5 spacing", last_span, PER + 4);
            prev = last_ch;
        end
    endtask

    task automatic t_bounds();
        int wv [N] = '{0, 1, PER, PER + 1, PER + 2, 1023};
        int ev [N] = '{0, 1, PER, PER + 1, PER + 1, PER + 1};
        for (int k = 0; k < N; k++) write_w(k, wv[k]);
        wait_leave(5);
        wait_leave(5);
        for (int k = 0; k < N; k++) begin
            check($sformatf("R3 bound width ch%0d", k), hist_w[k], ev[k]);
        end
        check("R4 cross-channel pulses", viol, 0);
    endtask

    task automatic t_update();
        for (int k = 0; k < N; k++) write_w(k, 4 + 2 * k);
        wait_leave(5);
        wait_leave(5);
        do @(negedge clk); while (!(ch_o == 3'd2 && servo_o[2]));
        wr_en = 1'b1; wr_addr = 3'd2; wr_data = 10'd11;
        @(negedge clk);
        wr_en = 1'b0;
        wait_leave(2);
        check("R6 in-flight pulse unchanged", hist_w[2], 8);
        wait_leave(2);
        check("R6 new width next frame", hist_w[2], 11);
        write_w(7, 3);
        wait_leave(5);
        wait_leave(5);
        check("R6 out-of-range addr ignored ch5", hist_w[5], 14);
        check("R6 out-of-range addr ignored ch1", hist_w[1], 6);
    endtask

    task automatic t_enable();
        int c;
        do @(negedge clk); while (servo_o == 6'd0);
        c = int'(ch_o);
        en = 1'b0;
        @(negedge clk);
        check("R8 outputs low after disable", int'(servo_o), 0);
        repeat (30) @(negedge clk);
        check("R8 outputs stay low", int'(servo_o), 0);
        check("R8 channel held", int'(ch_o), c);
        en = 1'b1;
        wait_leave(c);
        check("R8 full pulse after resume", hist_w[c], (c == 2) ? 11 : 4 + 2 * c);
        check("R4 cross-channel pulses", viol, 0);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_sweep();
                t_order();
                t_bounds();
                t_update();
                t_enable();
            end
            begin
                repeat (100000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule